// File: doc/BRIEF.md
# Trailing-Padding Final-Request Detector

This block serves a hashing engine that receives a message as a series of requests and keeps one hash state across them. It decides whether the request it is handed closes the message. It does not rely on a control flag for this. It looks for padding that software has already placed at the end of the request. It keeps a running byte total over all requests since the last close. For each request it fetches the trailing eight bytes through a byte-wide read port with one cycle of latency. It reads those bytes as a big-endian bit count and turns the count into a message byte length. From the difference between the running total and that length it locates where the padding should start. It then reads that single byte and accepts the request as final only when the byte holds the padding marker 0x80.

Each result comes with a one-cycle `res_valid` pulse. The pulse carries the final decision and the number of payload bytes in the request. On a final result the payload length is the padding start. On any other result it is the whole request length. A final result clears both the running total and the segment count. A non-final result adds the request length to the total and bumps the segment count. Any descriptor-list "last" marking that comes with the request is accepted on a port and has no effect on the decision.

Top module: `pad_final_detect`

## Requirements
- R1: After reset `run_total` and `seg_count` are 0, and `busy`, `rd_en` and `res_valid` are low.
- R2: A request is accepted when `req_valid` is high while `busy` is low. `req_valid` is ignored while `busy` is high, so each accepted request yields exactly one `res_valid` pulse.
- R3: The running sum for a request is `run_total + req_len`, modulo 2^TOT_W. A non-final result loads that sum into `run_total`, adds one to `seg_count`, and reports `res_pay_len = req_len`. Both counters are visible one cycle after the pulse.
- R4: A request with `req_len` below 8 gives a non-final result and issues no read.
- R5: The bytes at request offsets `req_len-8` through `req_len-1` form a 64-bit count, with offset `req_len-8` as the most significant byte. The message length is that count divided by 8, truncated to TOT_W bits.
- R6: If the message length exceeds the running sum, the result is non-final after exactly 8 reads.
- R7: The padding size is the running sum minus the message length. If it is zero or larger than `req_len`, the result is non-final after exactly 8 reads.
- R8: Otherwise the byte at offset `req_len - padding size` is read as a ninth read. If it equals 0x80 the result is final, `res_pay_len` equals that offset, and `run_total` and `seg_count` both become 0.
- R9: If that ninth byte is not 0x80 the result is non-final, and the counters follow R3.
- R10: Every read address lies below the request length, no request issues more than 9 reads, and `res_valid` never stays high for two cycles in a row.
- R11: `req_list_end` has no effect on any result or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_len | input | LEN_W | Request length in bytes |
| req_list_end | input | 1 | Descriptor-list end marking, inert |
| busy | output | 1 | A request is being examined |
| rd_en | output | 1 | Byte read strobe |
| rd_addr | output | LEN_W | Byte offset within the current request |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| res_valid | output | 1 | One-cycle result pulse |
| res_final | output | 1 | Request closes the message |
| res_pay_len | output | LEN_W | Payload bytes in the request |
| run_total | output | TOT_W | Running byte total |
| seg_count | output | SEG_W | Non-final requests since the last close |

## Verification
The bench aims at the edges of each rejection path. These are a padding size of exactly zero, a padding size one larger than the request, a message length one above the running sum, a correct count with a wrong marker byte, and a padding start at offset 0. A design that takes the count bytes in little-endian order, or that compares against the old total instead of the updated one, would misjudge the padded requests. A design that reads the marker byte when the padding size is zero would issue a read outside the request. A design that lets the list-end marking or a request arriving while busy steer the result would report a spurious close or a second result. Random mixes of padded and unpadded requests then check that the total and the segment count carry over correctly between requests.

// File: rtl/pad_detect_pkg.sv
package pad_detect_pkg;
   localparam int TAIL_BYTES = 8;
   localparam int BIT_SHIFT  = 3;
   localparam logic [7:0] PAD_MARK = 8'h80;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TAIL,
      ST_JUDGE,
      ST_CAND,
      ST_CMP,
      ST_DONE
   } det_state_t;
endpackage

// File: rtl/pad_tail_capture.sv
module pad_tail_capture #(
   parameter int LANES = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               shift_en,
   input  logic [7:0]         din,
   output logic [8*LANES-1:0] word
);
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("pad_tail_capture: LANES must be 1..8");
   end

   logic [7:0] lane_q [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        lane_q[0] <= '0;
            else if (clr)      lane_q[0] <= '0;
            else if (shift_en) lane_q[0] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        lane_q[i] <= '0;
            else if (clr)      lane_q[i] <= '0;
            else if (shift_en) lane_q[i] <= lane_q[i-1];
         end
      end
      assign word[8*i +: 8] = lane_q[i];
   end
endmodule

// File: rtl/pad_judge.sv
module pad_judge #(
   parameter int LEN_W = 16,
   parameter int TOT_W = 32,
   parameter int KW    = 40
) (
   input  logic [KW-1:0]    tail_word,
   input  logic [TOT_W-1:0] sum,
   input  logic [LEN_W-1:0] len,
   output logic             cand_ok,
   output logic [LEN_W-1:0] cand_off
);
   import pad_detect_pkg::*;

   logic [TOT_W-1:0] msg_len;
   logic [TOT_W-1:0] pad_sz;
   logic [TOT_W-1:0] len_ext;

   always_comb begin
      msg_len  = TOT_W'(tail_word >> BIT_SHIFT);
      len_ext  = TOT_W'(len);
      pad_sz   = sum - msg_len;
      cand_ok  = (msg_len <= sum) && (pad_sz != '0) && (pad_sz <= len_ext);
      cand_off = LEN_W'(len_ext - pad_sz);
   end
endmodule

// File: rtl/pad_total_track.sv
module pad_total_track #(
   parameter int TOT_W = 32,
   parameter int SEG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             fin,
   input  logic [TOT_W-1:0] sum,
   output logic [TOT_W-1:0] total,
   output logic [SEG_W-1:0] segs
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total <= '0;
         segs  <= '0;
      end else if (upd) begin
         total <= fin ? '0 : sum;
         segs  <= fin ? '0 : segs + 1'b1;
      end
   end

   assert_clear_on_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && fin) |=> (total == '0 && segs == '0));
   assert_carry_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !fin) |=> (total == $past(sum)));
endmodule

// File: rtl/pad_final_detect.sv
module pad_final_detect #(
   parameter int LEN_W = 16,
   parameter int TOT_W = 32,
   parameter int SEG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_list_end,
   output logic             busy,
   output logic             rd_en,
   output logic [LEN_W-1:0] rd_addr,
   input  logic [7:0]       rd_data,
   output logic             res_valid,
   output logic             res_final,
   output logic [LEN_W-1:0] res_pay_len,
   output logic [TOT_W-1:0] run_total,
   output logic [SEG_W-1:0] seg_count
);
   import pad_detect_pkg::*;

   localparam int LANES     = (TOT_W + BIT_SHIFT + 7) / 8;
   localparam int KW        = 8 * LANES;
   localparam int ISS_W     = $clog2(TAIL_BYTES + 1);
   localparam int MAX_READS = TAIL_BYTES + 1;

   if (LEN_W < 4)       begin : g_bad_len  $error("LEN_W too small"); end
   if (TOT_W < LEN_W)   begin : g_bad_tot  $error("TOT_W must cover LEN_W"); end
   if (LANES > TAIL_BYTES) begin : g_bad_kw $error("TOT_W too wide for count"); end
   if (SEG_W < 1)       begin : g_bad_seg  $error("SEG_W must be positive"); end

   det_state_t       state_q;
   logic [LEN_W-1:0] len_q;
   logic [TOT_W-1:0] sum_q;
   logic [ISS_W-1:0] iss_q;
   logic             dv_q;
   logic [LEN_W-1:0] off_q;
   logic             fin_q;
   logic [LEN_W-1:0] pay_q;
   logic [3:0]       rd_cnt_q;

   logic [KW-1:0]    tail_word;
   logic             cand_ok;
   logic [LEN_W-1:0] cand_off;
   logic             accept;
   logic             tail_done;

   assign accept    = (state_q == ST_IDLE) && req_valid;
   assign tail_done = (state_q == ST_TAIL) && (iss_q == ISS_W'(TAIL_BYTES)) && dv_q;

   always_comb begin
      rd_en   = 1'b0;
      rd_addr = '0;
      if (state_q == ST_TAIL && iss_q < ISS_W'(TAIL_BYTES)) begin
         rd_en   = 1'b1;
         rd_addr = len_q - LEN_W'(TAIL_BYTES) + LEN_W'(iss_q);
      end else if (state_q == ST_CAND) begin
         rd_en   = 1'b1;
         rd_addr = off_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= '0;
         sum_q   <= '0;
         iss_q   <= '0;
         dv_q    <= 1'b0;
         off_q   <= '0;
         fin_q   <= 1'b0;
         pay_q   <= '0;
      end else begin
         dv_q <= (state_q == ST_TAIL) && rd_en;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  len_q <= req_len;
                  sum_q <= run_total + TOT_W'(req_len);
                  iss_q <= '0;
                  if (req_len < LEN_W'(TAIL_BYTES)) begin
                     fin_q   <= 1'b0;
                     pay_q   <= req_len;
                     state_q <= ST_DONE;
                  end else begin
                     state_q <= ST_TAIL;
                  end
               end
            end
            ST_TAIL: begin
               if (rd_en) iss_q <= iss_q + 1'b1;
               if (tail_done) state_q <= ST_JUDGE;
            end
            ST_JUDGE: begin
               if (cand_ok) begin
                  off_q   <= cand_off;
                  state_q <= ST_CAND;
               end else begin
                  fin_q   <= 1'b0;
                  pay_q   <= len_q;
                  state_q <= ST_DONE;
               end
            end
            ST_CAND: state_q <= ST_CMP;
            ST_CMP: begin
               fin_q   <= (rd_data == PAD_MARK);
               pay_q   <= (rd_data == PAD_MARK) ? off_q : len_q;
               state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_cnt_q <= '0;
      else if (accept) rd_cnt_q <= '0;
      else if (rd_en)  rd_cnt_q <= rd_cnt_q + 1'b1;
   end

   pad_tail_capture #(.LANES(LANES)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .shift_en (dv_q),
      .din      (rd_data),
      .word     (tail_word)
   );

   pad_judge #(.LEN_W(LEN_W), .TOT_W(TOT_W), .KW(KW)) u_judge (
      .tail_word (tail_word),
      .sum       (sum_q),
      .len       (len_q),
      .cand_ok   (cand_ok),
      .cand_off  (cand_off)
   );

   pad_total_track #(.TOT_W(TOT_W), .SEG_W(SEG_W)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (state_q == ST_DONE),
      .fin   (fin_q),
      .sum   (sum_q),
      .total (run_total),
      .segs  (seg_count)
   );

   assign busy        = (state_q != ST_IDLE);
   assign res_valid   = (state_q == ST_DONE);
   assign res_final   = fin_q;
   assign res_pay_len = pay_q;

   assert_read_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr < len_q));
   assert_read_budget_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt_q <= 4'(MAX_READS));
   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   assert_reads_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> busy);
   assert_final_payload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_final) |-> (res_pay_len < len_q && rd_cnt_q == 4'(MAX_READS)));
   assert_short_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && len_q < LEN_W'(TAIL_BYTES)) |-> (rd_cnt_q == '0 && !res_final));
   assert_hint_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_list_end && req_len < LEN_W'(TAIL_BYTES)) |=> (res_valid && !res_final));
endmodule

// File: tb/pad_final_detect_bench.sv
module pad_final_detect_bench;
   localparam int LEN_W = 16;
   localparam int TOT_W = 32;
   localparam int SEG_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [LEN_W-1:0] req_len = '0;
   logic             req_list_end = 1'b0;
   logic             busy, rd_en, res_valid, res_final;
   logic [LEN_W-1:0] rd_addr, res_pay_len;
   logic [7:0]       rd_data;
   logic [TOT_W-1:0] run_total;
   logic [SEG_W-1:0] seg_count;

   logic [7:0] mem [256];
   int n_tests = 0, n_fail = 0;
   int n_reads = 0, n_pulses = 0;
   logic [TOT_W-1:0] exp_total = '0;
   logic [SEG_W-1:0] exp_seg = '0;

   always #5 clk = ~clk;

   pad_final_detect #(.LEN_W(LEN_W), .TOT_W(TOT_W), .SEG_W(SEG_W)) u_pad_final_detect (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
      .req_list_end(req_list_end), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .res_valid(res_valid), .res_final(res_final),
      .res_pay_len(res_pay_len), .run_total(run_total), .seg_count(seg_count)
   );

   always @(posedge clk) begin
      if (rd_en) begin
         rd_data <= mem[rd_addr[7:0]];
         n_reads <= n_reads + 1;
      end
      if (res_valid) n_pulses <= n_pulses + 1;
   end

   task automatic check(input string tag, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic ref_model(input int len, output bit fin, output int pay, output int nrd);
      logic [TOT_W-1:0] sum, msg, pad;
      logic [63:0] cnt;
      sum = exp_total + TOT_W'(len);
      fin = 0; pay = len; nrd = 0;
      if (len >= 8) begin
         cnt = '0;
         for (int k = 0; k < 8; k++) cnt = {cnt[55:0], mem[len-8+k]};
         msg = TOT_W'(cnt >> 3);
         nrd = 8;
         pad = sum - msg;
         if (msg <= sum && pad != 0 && pad <= TOT_W'(len)) begin
            nrd = 9;
            if (mem[len - int'(pad)] == 8'h80) begin
               fin = 1;
               pay = len - int'(pad);
            end
         end
      end
   endtask

   task automatic put_count(input int len, input logic [63:0] bits);
      for (int k = 0; k < 8; k++) mem[len-8+k] = bits[63-8*k -: 8];
   endtask

   task automatic fill_rand();
      for (int k = 0; k < 256; k++) mem[k] = 8'($urandom);
   endtask

   task automatic run_req(input int len, input bit hint, input int hold, input string tag);
      bit fin; int pay, nrd, r0, p0, guard;
      ref_model(len, fin, pay, nrd);
      r0 = n_reads; p0 = n_pulses;
      @(negedge clk);
      req_valid = 1'b1; req_len = LEN_W'(len); req_list_end = hint;
      for (int h = 0; h < hold; h++) @(negedge clk);
      req_valid = 1'b0; req_list_end = 1'b0;
      guard = 0;
      while (!res_valid && guard < 100) begin @(negedge clk); guard++; end
      check({tag, " R2 result seen"}, res_valid, 1);
      check({tag, " final R8"}, res_final, fin);
      check({tag, " payload R3"}, res_pay_len, pay);
      @(negedge clk);
      if (fin) begin exp_total = '0; exp_seg = '0; end
      else begin exp_total = exp_total + TOT_W'(len); exp_seg = exp_seg + 1'b1; end
      repeat (3) @(negedge clk);
      check({tag, " reads R10"}, n_reads - r0, nrd);
      check({tag, " pulses R2"}, n_pulses - p0, 1);
      check({tag, " total R3"}, run_total, exp_total);
      check({tag, " segs R3"}, seg_count, exp_seg);
      check({tag, " idle R2"}, busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 total", run_total, 0);
      check("R1 segs", seg_count, 0);
      check("R1 busy", busy, 0);
      check("R1 valid", res_valid, 0);
      check("R1 rd_en", rd_en, 0);
      rst_n = 1'b1;
      void'($urandom(32'h5eed_1234));

      fill_rand();
      run_req(5, 0, 1, "R4 short");
      run_req(7, 1, 1, "R11 short hinted");
      fill_rand();
      // R6: message length one above the running sum
      put_count(40, 64'(exp_total + 40 + 1) << 3);
      run_req(40, 1, 1, "R6 msg over sum");
      // R7: padding size zero
      fill_rand();
      put_count(30, 64'(exp_total + 30) << 3);
      run_req(30, 0, 1, "R7 pad zero");
      // R7: padding one beyond request
      fill_rand();
      put_count(20, 64'(exp_total + 20 - 21) << 3);
      run_req(20, 0, 1, "R7 pad over len");
      // R9: right count, wrong marker
      fill_rand();
      put_count(64, 64'(exp_total + 64 - 20) << 3);
      mem[44] = 8'h81;
      run_req(64, 0, 1, "R9 bad marker");
      // R8 + R5: padding starts at offset 0, held request while busy (R2)
      fill_rand();
      put_count(50, 64'(exp_total + 50 - 50) << 3);
      mem[0] = 8'h80;
      run_req(50, 1, 4, "R8 offset zero");
      // R8 with low count bits set (truncating divide) and R11 hint
      fill_rand();
      put_count(100, (64'(exp_total + 100 - 37) << 3) | 64'd5);
      mem[63] = 8'h80;
      run_req(100, 1, 1, "R5 R8 frac bits");
      // R11: list end marking with plain data
      fill_rand();
      run_req(90, 1, 1, "R11 hinted plain");

      for (int it = 0; it < 300; it++) begin
         int len, pad, sel;
         fill_rand();
         sel = int'($urandom_range(0, 9));
         if (sel < 4) begin
            len = int'($urandom_range(9, 200));
            pad = int'($urandom_range(9, len));
            put_count(len, 64'(exp_total + TOT_W'(len) - TOT_W'(pad)) << 3);
            mem[len - pad] = 8'h80;
         end else if (sel < 6) begin
            len = int'($urandom_range(9, 200));
            pad = int'($urandom_range(9, len));
            put_count(len, 64'(exp_total + TOT_W'(len) - TOT_W'(pad)) << 3);
            mem[len - pad] = 8'($urandom_range(0, 127));
         end else begin
            len = int'($urandom_range(1, 200));
         end
         run_req(len, 1'($urandom), 1, "rand R3 R8");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule